// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Generator

This block derives the bit clock and the frame clock of one master-mode audio serial port from a single master clock. Two configuration fields set the ratio of the master clock to the frame rate: 128, 192, 256 or 384 times. They also set the number of bit clocks per frame: 32 or 64. From these two fields the block computes the master-clock-to-bit-clock divisor, which is one of 2, 3, 4, 6, 8 or 12. One of these, 3, is odd. The block then counts bit clocks to produce the frame clock.

The whole block runs in the master clock domain, and every output is a register. A clock-enable input starts and stops the clocks. Configuration writes are taken only while the enable is low. Each enable rise restarts the sequence from a clean left-channel half. Besides the two clocks, the block gives a channel indicator and a one-cycle frame-start strobe for the data path downstream. With the default setting of 256 times and 64 bits, a 4.096 MHz master clock yields a 1.024 MHz bit clock and a 16 kHz frame clock.

Top module: `aud_bitclk_gen`

## Requirements
- R1: The ratio code `cfg_osr` maps 0, 1, 2 and 3 to 128, 192, 256 and 384 master clocks per frame. `cfg_wide` = 0 selects 32 bit clocks per frame and 1 selects 64. The bit clock period is D = ratio / bits-per-frame master-clock cycles, which gives 4, 6, 8 or 12 for 32 bits and 2, 3, 4 or 6 for 64 bits.
- R2: Each bit clock period starts with `sck` low for D - floor(D/2) master cycles, followed by `sck` high for floor(D/2) cycles. For D = 3 this gives 2 low and 1 high.
- R3: `lrck` holds each level for exactly half a frame: 16 bit clock periods with 32 bits per frame, or 32 periods with 64. It changes only in the cycle where `sck` falls.
- R4: After `clk_en` rises, the first frame begins with `lrck` low (left channel). Its low half lasts the full half-frame length, counted from the first enabled master clock edge.
- R5: While `clk_en` is low, `sck`, `lrck`, `ch_right` and `frame_start` are low from the next master clock edge onward.
- R6: A configuration write (`cfg_we` high) takes effect only while `clk_en` is low. A write while enabled is ignored, and the running waveform keeps its old ratio.
- R7: `frame_start` is high for one master cycle, in the same cycle that `lrck` goes from high to low. It is never high for the very first frame after enable.
- R8: `ch_right` is the channel of the bit on the data line. It takes the value `lrck` had during the previous bit clock period, so it lags each `lrck` change by one bit clock period. It is low for the first period.
- R9: Reset (`rst_n` low at a master clock edge, synchronous) drives all outputs low and loads the default configuration: ratio code 2 (256x) with 64 bits per frame, so D = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Runs the clocks when high; holds them low and allows configuration when low |
| cfg_we | input | 1 | Configuration write strobe, honoured only while clk_en is low |
| cfg_osr | input | 2 | Ratio code: 0=128x, 1=192x, 2=256x, 3=384x |
| cfg_wide | input | 1 | Bits per frame: 0=32, 1=64 |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock, low = left, high = right |
| ch_right | output | 1 | Channel of the current data bit, high = right |
| frame_start | output | 1 | One-cycle strobe at each lrck falling transition |

## Verification
The first rising master clock edge with `clk_en` high is edge 0. After edge n, every output is a pure function of n: `sck` depends on n mod D, `lrck` on n divided by the half-frame length, and `ch_right` and `frame_start` on the bit clock period index. The bench drives enable and configuration at falling edges and samples one falling edge after each rising edge. This lets it compare each sample against the value computed for that n over more than two frames, for all eight settings. A reset or a drop of `clk_en` shows up one rising edge later, and the bench samples at the next falling edge. An ignored write is checked by confirming that the waveform still follows the old divisor after it.

// File: rtl/aud_clk_pkg.sv
// Package: shared configuration type and ratio arithmetic for the audio
// bit/frame clock generator. Assumes ratio codes and width code as in the brief.
package aud_clk_pkg;

    localparam int MAX_DIV   = 12;
    localparam int DIV_W     = $clog2(MAX_DIV + 1);
    localparam int MAX_HALF  = 32;
    localparam int HALF_W    = $clog2(MAX_HALF);
    localparam int BASE_BITS = 32;

    typedef enum logic [1:0] {
        OSR_X128 = 2'd0,
        OSR_X192 = 2'd1,
        OSR_X256 = 2'd2,
        OSR_X384 = 2'd3
    } osr_code_e;

    typedef struct packed {
        osr_code_e osr;
        logic      wide;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_DEFAULT = '{osr: OSR_X256, wide: 1'b1};

    // Master clocks per frame for a ratio code.
    function automatic int unsigned osr_ratio(osr_code_e c);
        case (c)
            OSR_X128: return 128;
            OSR_X192: return 192;
            OSR_X256: return 256;
            default:  return 384;
        endcase
    endfunction

    // Master clocks per bit clock period: ratio / bits per frame.
    function automatic logic [DIV_W-1:0] sck_divisor(clk_cfg_t c);
        int unsigned bits;
        bits = c.wide ? 2 * BASE_BITS : BASE_BITS;
        return DIV_W'(osr_ratio(c.osr) / bits);
    endfunction

    // Last index of the bit counter within one half frame.
    function automatic logic [HALF_W-1:0] half_last(logic wide);
        return wide ? HALF_W'(BASE_BITS - 1) : HALF_W'(BASE_BITS / 2 - 1);
    endfunction

endpackage

// File: rtl/aud_cfg_reg.sv
// Configuration holding register. Loads cfg_in on cfg_we only while the
// clocks are stopped (en low); assumes en is synchronous to clk.
module aud_cfg_reg
    import aud_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     we,
    input  clk_cfg_t cfg_in,
    output clk_cfg_t cfg_q
);

    // Hold configuration; accept writes only when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_DEFAULT;
        end else if (we && !en) begin
            cfg_q <= cfg_in;
        end
    end

    // R6: configuration is frozen across any enabled cycle
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg_q));

endmodule

// File: rtl/aud_sck_div.sv
// Bit clock divider. Divides clk by div (2..MAX_DIV, odd allowed) with a
// low phase of div - div/2 cycles then a high phase of div/2 cycles, single
// edge only. Assumes div is constant while en is high. Gives per_start in
// the cycle whose edge begins a new bit clock period (sck falls there).
module aud_sck_div #(
    parameter int DIV_W = aud_clk_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             per_start
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lo_len;
    logic             sck_q;

    // Length of the low phase (the longer phase for odd divisors).
    assign lo_len    = div - (div >> 1);
    // Edge that opens a new bit clock period.
    assign per_start = en && (cnt_q == '0);

    // Phase counter and registered bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == div - 1'b1) ? '0 : cnt_q + 1'b1;
            sck_q <= (cnt_q >= lo_len);
        end
    end

    assign sck = sck_q;

    // R1: phase counter stays within the selected divisor
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div);

    // R2: a high phase never lasts longer than one cycle for divisor 2 or 3
    p_short_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div < 4 && sck_q) |=> !sck_q);

endmodule

// File: rtl/aud_frame_ctr.sv
// Frame clock stage. Counts bit clock periods (per_start) and toggles the
// frame clock every half frame, starting low after enable. Also derives the
// data-bit channel flag (one period behind) and the frame-start strobe.
// Assumes per_start comes from aud_sck_div in the same clock domain.
module aud_frame_ctr
    import aud_clk_pkg::*;
#(
    parameter int HALF_W = aud_clk_pkg::HALF_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic per_start,
    input  logic wide,
    output logic lrck,
    output logic ch_right,
    output logic frame_start
);

    logic [HALF_W-1:0] bcnt_q;
    logic [HALF_W-1:0] last_idx;
    logic              run_q;
    logic              lrck_q;
    logic              ch_q;
    logic              fs_q;
    logic              flip;

    assign last_idx = half_last(wide);
    // Toggle at the start of every period whose index wraps, except the first.
    assign flip     = per_start && run_q && (bcnt_q == '0);

    // Period counter, frame clock, channel flag and frame-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q  <= 1'b0;
            bcnt_q <= '0;
            lrck_q <= 1'b0;
            ch_q   <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            fs_q <= flip && lrck_q;
            if (per_start) begin
                run_q  <= 1'b1;
                bcnt_q <= (bcnt_q == last_idx) ? '0 : bcnt_q + 1'b1;
                ch_q   <= lrck_q;
            end
            if (flip) begin
                lrck_q <= ~lrck_q;
            end
        end
    end

    assign lrck        = lrck_q;
    assign ch_right    = ch_q;
    assign frame_start = fs_q;

    // R7: strobe only in the cycle the frame clock has just fallen
    p_fs_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q |-> (!lrck_q && $past(lrck_q)));

    // R7: strobe is a single cycle wide
    p_fs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q |=> !fs_q);

    // R8: channel flag never changes in the same cycle as the frame clock
    p_ch_lags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && lrck_q != $past(lrck_q)) |-> $stable(ch_q));

endmodule

// File: rtl/aud_bitclk_gen.sv
// Top: audio serial master clock generator. Produces bit clock, frame clock,
// channel flag and frame-start strobe from mclk using the ratio and width
// held in the configuration register. Assumes clk_en and cfg_* are
// synchronous to mclk; all outputs are registered.
module aud_bitclk_gen
    import aud_clk_pkg::*;
(
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       cfg_we,
    input  logic [1:0] cfg_osr,
    input  logic       cfg_wide,
    output logic       sck,
    output logic       lrck,
    output logic       ch_right,
    output logic       frame_start
);

    clk_cfg_t         cfg_in;
    clk_cfg_t         cfg_q;
    logic [DIV_W-1:0] div;
    logic             per_start;

    // Pack the configuration inputs.
    assign cfg_in = '{osr: osr_code_e'(cfg_osr), wide: cfg_wide};
    // Divisor derived from the held configuration.
    assign div    = sck_divisor(cfg_q);

    aud_cfg_reg u_cfg (
        .clk    (mclk),
        .rst_n  (rst_n),
        .en     (clk_en),
        .we     (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    aud_sck_div #(.DIV_W(DIV_W)) u_div (
        .clk       (mclk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .div       (div),
        .sck       (sck),
        .per_start (per_start)
    );

    aud_frame_ctr #(.HALF_W(HALF_W)) u_frame (
        .clk         (mclk),
        .rst_n       (rst_n),
        .en          (clk_en),
        .per_start   (per_start),
        .wide        (cfg_q.wide),
        .lrck        (lrck),
        .ch_right    (ch_right),
        .frame_start (frame_start)
    );

    // R3: the frame clock moves only together with a bit clock fall
    p_lrck_on_fall_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        (clk_en && $past(clk_en) && lrck != $past(lrck)) |-> $fell(sck));

    // R5: stopped clocks give quiet outputs one edge later
    p_quiet_off_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        !clk_en |=> (!sck && !lrck && !ch_right && !frame_start));

    // R4: first enabled edge starts with bit clock low and the left channel
    p_start_left_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        (clk_en && !$past(clk_en)) |=> (!sck && !lrck));

endmodule

// File: tb/sim_aud_bitclk_gen.sv
module sim_aud_bitclk_gen;

    logic       mclk = 1'b0;
    logic       rst_n;
    logic       clk_en;
    logic       cfg_we;
    logic [1:0] cfg_osr;
    logic       cfg_wide;
    logic       sck, lrck, ch_right, frame_start;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 mclk = ~mclk;

    aud_bitclk_gen u0 (
        .mclk(mclk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we),
        .cfg_osr(cfg_osr), .cfg_wide(cfg_wide), .sck(sck), .lrck(lrck),
        .ch_right(ch_right), .frame_start(frame_start)
    );

    task automatic check(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ratio_of(int code);
        case (code)
            0: return 128;
            1: return 192;
            2: return 256;
            default: return 384;
        endcase
    endfunction

    function automatic int exp_lrck(int n, int d, int h);
        return (n / (h * d)) % 2;
    endfunction

    // Check all four outputs are low now.
    task automatic check_quiet(string tag);
        check(tag, {sck, lrck, ch_right, frame_start}, 0, "outputs while stopped/reset");
    endtask

    // Stop, optionally write config, then start (drives at a falling edge).
    task automatic start(bit wr, int osr, int wide);
        @(negedge mclk);
        clk_en   = 1'b0;
        cfg_we   = wr;
        cfg_osr  = 2'(osr);
        cfg_wide = wide[0];
        @(negedge mclk);
        cfg_we   = 1'b0;
        clk_en   = 1'b1;
    endtask

    // Compare nsamp samples after the first enabled edge against the model.
    // A poke writes another setting while enabled (must be ignored).
    task automatic run_wave(string tag, int osr, int wide, bit poke);
        int d = ratio_of(osr) / (wide ? 64 : 32);
        int h = wide ? 32 : 16;
        int lo = d - d / 2;
        int nsamp = 2 * (2 * h * d) + 3 * d;
        int e_sck = 0, e_lr = 0, e_ch = 0, e_fs = 0;
        int rises = 0, last_rise = -1, per_err = 0;
        bit prev_sck = 0;
        for (int n = 0; n < nsamp; n++) begin
            int xs, xl, xc, xf, k;
            @(negedge mclk);
            k  = n / d;
            xs = ((n % d) >= lo) ? 1 : 0;
            xl = exp_lrck(n, d, h);
            xc = (k == 0) ? 0 : exp_lrck(k * d - 1, d, h);
            xf = (n > 0 && n % (2 * h * d) == 0) ? 1 : 0;
            if (sck != xs[0])         begin if (e_sck == 0) $display("  %s n=%0d sck=%0b", tag, n, sck); e_sck++; end
            if (lrck != xl[0])        e_lr++;
            if (ch_right != xc[0])    e_ch++;
            if (frame_start != xf[0]) e_fs++;
            if (sck && !prev_sck) begin
                if (last_rise >= 0 && n - last_rise != d) per_err++;
                last_rise = n;
                rises++;
            end
            prev_sck = sck;
            if (poke && n == 5) begin
                cfg_we = 1'b1; cfg_osr = 2'(3 - osr); cfg_wide = ~wide[0];
            end
            if (poke && n == 6) cfg_we = 1'b0;
        end
        check({tag, " R1"}, per_err, 0, "sck periods not equal to divisor");
        check({tag, " R2"}, e_sck, 0, "sck duty/phase mismatches");
        check({tag, " R3"}, e_lr, 0, "lrck half-frame mismatches");
        check({tag, " R7"}, e_fs, 0, "frame_start mismatches");
        check({tag, " R8"}, e_ch, 0, "ch_right mismatches");
    endtask

    task automatic t_reset_defaults();
        rst_n = 1'b0; clk_en = 1'b0; cfg_we = 1'b0; cfg_osr = 2'd0; cfg_wide = 1'b0;
        repeat (3) @(negedge mclk);
        check_quiet("R9 reset");
        rst_n = 1'b1;
        clk_en = 1'b1;
        run_wave("R9 default 256x/64", 2, 1, 1'b0);
    endtask

    task automatic t_all_ratios();
        for (int w = 0; w < 2; w++)
            for (int o = 0; o < 4; o++) begin
                start(1'b1, o, w);
                run_wave($sformatf("R1 R4 osr=%0d wide=%0d", o, w), o, w, 1'b0);
            end
    endtask

    task automatic t_write_while_on();
        start(1'b1, 0, 0);
        run_wave("R6 write ignored", 0, 0, 1'b1);
    endtask

    task automatic t_stop();
        start(1'b1, 1, 1);
        repeat (40) @(negedge mclk);
        clk_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge mclk);
            check_quiet("R5 stopped");
        end
        clk_en = 1'b1;
        run_wave("R4 restart left half", 1, 1, 1'b0);
    endtask

    task automatic t_mid_reset();
        start(1'b1, 3, 0);
        repeat (50) @(negedge mclk);
        rst_n = 1'b0;
        @(negedge mclk);
        check_quiet("R9 mid-run reset");
        rst_n = 1'b1;
        run_wave("R9 reverts to default", 2, 1, 1'b0);
    endtask

    initial begin
        t_reset_defaults();
        t_all_ratios();
        t_write_while_on();
        t_stop();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge mclk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule